// File: doc/BRIEF.md
# Cubic INL Correction Code Generator

This block sits beside a 14-bit main DAC and, for every code sent to it, works out how far the analog output is expected to stray from ideal. It evaluates a stored third-order error polynomial at the current code. The result becomes a signed 6-bit code for a small auxiliary DAC, and the outputs of the two DACs are summed in the analog domain. The main code leaves the block delayed by the same number of cycles as the correction, so the two codes always belong to the same sample. A new sample can enter on every clock.

The polynomial is evaluated in Horner form over three registered multiply-add stages. The input code is mapped to a signed value centred on mid-scale, and each multiply is scaled back by the half-range of the code. Coefficients are signed and carry 8 fraction bits, so one unit is 1/256 of a main-DAC LSB. The auxiliary DAC step is 1/16 LSB. The off-line measurement loads the coefficients into shadow registers, and a load strobe copies the whole set into use between two samples. Each sample takes its own snapshot of the set when it enters the pipeline. A per-sample bypass flag forces that sample's correction to zero.

Top module: `inl_corr_gen`

## Requirements
- R1: Let xs = in_code − 8192. Starting from acc = b3, three steps acc = floor(acc·xs / 8192) + bk are applied with k = 2, 1, 0, and the result is in units of 1/256 LSB.
- R2: The correction code is floor((acc + 8) / 16), which rounds halves towards plus infinity, for example acc = 24 gives 2 and acc = −24 gives −1.
- R3: A rounded value above +31 is output as +31, and one below −32 is output as −32. The value never wraps.
- R4: A sample presented with in_valid before clock edge n appears on out_valid, out_code and out_corr after edge n+3, and out_code equals the input code. out_valid is low in every cycle that corresponds to an idle input.
- R5: A sample with in_bypass high produces out_corr = 0, whatever the coefficients are.
- R6: A write with cfg_we stores cfg_data into shadow slot cfg_sel and has no effect on the corrections until cfg_load is pulsed.
- R7: The set copied by cfg_load applies only to samples that enter after the edge that samples the strobe. A sample that enters on that same edge uses the old set. No sample ever mixes coefficients from two sets.
- R8: After reset, out_valid is 0, out_code is 0 and out_corr is 0, and all coefficients are zero.
- R9: cfg_sel value k selects coefficient bk, the coefficient of xs^k in the polynomial above.
- R10: Samples can be presented back to back, one per clock, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A main DAC code is present this cycle |
| in_code | input | 14 | Main DAC code (unsigned) |
| in_bypass | input | 1 | Force this sample's correction to zero |
| cfg_we | input | 1 | Write cfg_data into a shadow coefficient |
| cfg_sel | input | 2 | Shadow coefficient index (k of bk) |
| cfg_data | input | 16 | Signed coefficient, 8 fraction bits |
| cfg_load | input | 1 | Copy all shadow coefficients into use |
| out_valid | output | 1 | Output sample valid |
| out_code | output | 14 | Delayed main DAC code |
| out_corr | output | 6 | Signed auxiliary DAC correction code |

## Verification
The bench targets rounding at exact half steps for both signs. A design that truncated, or rounded half away from zero, would return 1 or −2 where the right answer is 2 or −1. It drives coefficients that push the sum far past the 6-bit range, where wrap-around would show a sign flip in place of +31 or −32. It writes shadow coefficients without a load and pulses cfg_load in the same cycle as a sample. A design that let writes through early, or took a coefficient late in a deeper stage, would return a mix of the old and new set on the samples next to the boundary. Code extremes 0 and 16383 test the floor behaviour of the scaled multiply on both sides of mid-scale.

// File: rtl/inl_corr_pkg.sv
package inl_corr_pkg;

    localparam int CODE_W   = 14;                  // main DAC code width
    localparam int COEF_W   = 16;                  // signed coefficient width
    localparam int FRAC_W   = 8;                   // coefficient fraction bits (sub-LSB)
    localparam int AUX_W    = 6;                   // auxiliary DAC code width
    localparam int AUX_FRAC = 4;                   // aux DAC step = 2^-AUX_FRAC LSB
    localparam int N_COEF   = 4;                   // cubic: b0..b3
    localparam int SEL_W    = $clog2(N_COEF);
    localparam int ACC_W    = COEF_W + N_COEF - 1; // growth of one bit per stage
    localparam int RND_SH   = FRAC_W - AUX_FRAC;
    localparam int PROD_W   = ACC_W + CODE_W;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [N_COEF-1:0][COEF_W-1:0] coef_set_t;

    typedef struct packed {
        logic                     valid;
        logic                     bypass;
        logic [CODE_W-1:0]        code;
        logic signed [CODE_W-1:0] xs;
        logic signed [ACC_W-1:0]  acc;
        coef_set_t                coef;
    } smp_t;

    // One Horner step: floor(acc * xs / 2^(CODE_W-1)) + c
    function automatic logic signed [ACC_W-1:0] mac_step(
        input logic signed [ACC_W-1:0]  acc,
        input logic signed [CODE_W-1:0] xs,
        input logic signed [COEF_W-1:0] c
    );
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] scaled;
        logic signed [ACC_W-1:0]  c_ext;
        prod   = PROD_W'(acc) * PROD_W'(xs);
        scaled = prod >>> (CODE_W - 1);
        c_ext  = {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
        return scaled[ACC_W-1:0] + c_ext;
    endfunction

endpackage

// File: rtl/inl_coef_bank.sv
module inl_coef_bank
    import inl_corr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              load,
    output coef_set_t         active
);

    typedef struct packed {
        coef_set_t shadow;
        coef_set_t live;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) begin
            bank_d.live = bank_q.shadow;
        end
        if (wr_en) begin
            bank_d.shadow[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active = bank_q.live;

    // R7: the strobe copies the complete shadow set at once
    a_r7_load_whole_set: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bank_q.live == $past(bank_q.shadow)));

    // R6: without a strobe the coefficients in use never move
    a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q.live));

endmodule

// File: rtl/inl_horner_stage.sv
module inl_horner_stage
    import inl_corr_pkg::*;
#(
    parameter int TERM = 0
)(
    input  logic clk,
    input  logic rst_n,
    input  smp_t s_in,
    output smp_t s_out
);

    smp_t stg_d, stg_q;

    always_comb begin
        stg_d     = s_in;
        stg_d.acc = mac_step(s_in.acc, s_in.xs, s_in.coef[TERM]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign s_out = stg_q;

    // R7: the coefficient snapshot travels unchanged with its sample
    a_r7_snapshot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        s_in.valid |=> (stg_q.coef == $past(s_in.coef)));

endmodule

// File: rtl/inl_round_sat.sv
module inl_round_sat
    import inl_corr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  smp_t                    s_in,
    output logic                    out_valid,
    output logic [CODE_W-1:0]       out_code,
    output logic signed [AUX_W-1:0] out_corr
);

    localparam int AUX_MAX = 2 ** (AUX_W - 1) - 1;
    localparam int AUX_MIN = -(2 ** (AUX_W - 1));
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (RND_SH - 1));
    localparam logic signed [ACC_W-1:0] RMAX = ACC_W'(AUX_MAX);
    localparam logic signed [ACC_W-1:0] RMIN = ACC_W'(AUX_MIN);
    // accumulator bounds beyond which the output must sit on a rail
    localparam logic signed [ACC_W-1:0] CLIP_HI = ACC_W'((AUX_MAX + 1) * (2 ** RND_SH) - 2 ** (RND_SH - 1));
    localparam logic signed [ACC_W-1:0] CLIP_LO = ACC_W'(AUX_MIN * (2 ** RND_SH) - 2 ** (RND_SH - 1));

    typedef struct packed {
        logic                    valid;
        logic [CODE_W-1:0]       code;
        logic signed [AUX_W-1:0] corr;
    } out_t;

    out_t out_d, out_q;
    logic signed [ACC_W-1:0] acc_in;
    logic signed [ACC_W-1:0] rounded;

    always_comb begin
        acc_in  = $signed(s_in.acc);
        rounded = (acc_in + HALF) >>> RND_SH;
        out_d.valid = s_in.valid;
        out_d.code  = s_in.code;
        if (s_in.bypass) begin
            out_d.corr = '0;
        end else if (rounded > RMAX) begin
            out_d.corr = AUX_W'(AUX_MAX);
        end else if (rounded < RMIN) begin
            out_d.corr = AUX_W'(AUX_MIN);
        end else begin
            out_d.corr = rounded[AUX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_code  = out_q.code;
    assign out_corr  = out_q.corr;

    // R5: a bypassed sample leaves with a zero correction
    a_r5_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in.valid && s_in.bypass) |=> (out_corr == '0));

    // R3: large positive sums pin to the top rail
    a_r3_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in.valid && !s_in.bypass && ($signed(s_in.acc) >= CLIP_HI))
        |=> (out_corr == AUX_W'(AUX_MAX)));

    // R3: large negative sums pin to the bottom rail
    a_r3_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in.valid && !s_in.bypass && ($signed(s_in.acc) < CLIP_LO))
        |=> (out_corr == AUX_W'(AUX_MIN)));

endmodule

// File: rtl/inl_corr_gen.sv
module inl_corr_gen
    import inl_corr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [CODE_W-1:0]       in_code,
    input  logic                    in_bypass,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [COEF_W-1:0]       cfg_data,
    input  logic                    cfg_load,
    output logic                    out_valid,
    output logic [CODE_W-1:0]       out_code,
    output logic signed [AUX_W-1:0] out_corr
);

    localparam int N_STAGE = N_COEF - 1;
    localparam int LAT     = N_STAGE + 1;

    coef_set_t active;
    smp_t      entry;
    smp_t      stage_q [N_STAGE];

    inl_coef_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .load    (cfg_load),
        .active  (active)
    );

    // entry: centre the code on mid-scale and seed Horner with the top term
    always_comb begin
        entry.valid  = in_valid;
        entry.bypass = in_bypass;
        entry.code   = in_code;
        entry.xs     = {~in_code[CODE_W-1], in_code[CODE_W-2:0]};
        entry.acc    = {{(ACC_W-COEF_W){active[N_COEF-1][COEF_W-1]}}, active[N_COEF-1]};
        entry.coef   = active;
    end

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        if (g == 0) begin : g_first
            inl_horner_stage #(.TERM(N_COEF - 2 - g)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .s_in  (entry),
                .s_out (stage_q[g])
            );
        end else begin : g_next
            inl_horner_stage #(.TERM(N_COEF - 2 - g)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .s_in  (stage_q[g-1]),
                .s_out (stage_q[g])
            );
        end
    end

    inl_round_sat u_round (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_in      (stage_q[N_STAGE-1]),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_corr  (out_corr)
    );

    // R4: fixed latency, main code delay-matched to the correction
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##LAT (out_valid && (out_code == $past(in_code, LAT))));

    // R4: an idle input slot stays idle at the output
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##LAT !out_valid);

endmodule

// File: tb/sim_inl_corr_gen.sv
module sim_inl_corr_gen;
    import inl_corr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              in_valid = 1'b0;
    logic [CODE_W-1:0] in_code = '0;
    logic              in_bypass = 1'b0;
    logic              cfg_we = 1'b0;
    logic [SEL_W-1:0]  cfg_sel = '0;
    logic [COEF_W-1:0] cfg_data = '0;
    logic              cfg_load = 1'b0;
    logic                    out_valid;
    logic [CODE_W-1:0]       out_code;
    logic signed [AUX_W-1:0] out_corr;

    inl_corr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_bypass(in_bypass), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cfg_load(cfg_load), .out_valid(out_valid),
        .out_code(out_code), .out_corr(out_corr)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic        h_v    [8];
    logic [13:0] h_code [8];
    int          h_corr [8];
    string       h_tag  [8];
    longint      sh  [4];
    longint      act [4];

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // raw correction before clipping, from R1 and R2
    function automatic longint raw_corr(input logic [13:0] code);
        longint xs;
        longint acc;
        xs  = longint'(code) - 8192;
        acc = act[3];
        acc = ((acc * xs) >>> 13) + act[2];
        acc = ((acc * xs) >>> 13) + act[1];
        acc = ((acc * xs) >>> 13) + act[0];
        return (acc + 8) >>> 4;
    endfunction

    task automatic step(input logic v, input logic [13:0] code, input logic byp,
                        input logic we, input logic [1:0] sel, input logic [15:0] data,
                        input logic ld, input string tag);
        int k;
        longint r;
        int e;
        string t;
        @(negedge clk);
        k = (cyc + 4) & 7;   // slot written four cycles ago
        if (cyc >= 4 && h_v[k]) begin
            chk("R4 valid", int'(out_valid), 1);
            chk("R4 code", int'(out_code), int'(h_code[k]));
            chk(h_tag[k], int'(out_corr), h_corr[k]);
        end else begin
            chk("R4 idle", int'(out_valid), 0);
        end
        in_valid = v; in_code = code; in_bypass = byp;
        cfg_we = we; cfg_sel = sel; cfg_data = data; cfg_load = ld;
        r = raw_corr(code);
        t = "R1";
        if (byp) begin
            e = 0; t = "R5";
        end else if (r > 31) begin
            e = 31; t = "R3";
        end else if (r < -32) begin
            e = -32; t = "R3";
        end else begin
            e = int'(r);
        end
        if (tag != "") t = tag;
        k = cyc & 7;
        h_v[k] = v; h_code[k] = code; h_corr[k] = e; h_tag[k] = t;
        if (ld) for (int i = 0; i < 4; i++) act[i] = sh[i];
        if (we) sh[sel] = longint'($signed(data));
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, '0, 0, "");
    endtask

    task automatic load_set(input int c0, input int c1, input int c2, input int c3);
        step(0, '0, 0, 1, 2'd0, 16'(c0), 0, "");
        step(0, '0, 0, 1, 2'd1, 16'(c1), 0, "");
        step(0, '0, 0, 1, 2'd2, 16'(c2), 0, "");
        step(0, '0, 0, 1, 2'd3, 16'(c3), 0, "");
        step(0, '0, 0, 0, '0, '0, 1, "");
    endtask

    task automatic sample(input logic [13:0] code, input logic byp, input string tag);
        step(1, code, byp, 0, '0, '0, 0, tag);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 8; i++) h_v[i] = 1'b0;
        for (int i = 0; i < 4; i++) begin sh[i] = 0; act[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8 valid", int'(out_valid), 0);
        chk("R8 code", int'(out_code), 0);
        chk("R8 corr", int'(out_corr), 0);
        // R8: coefficients start at zero
        sample(14'd0, 0, "R8"); sample(14'd8192, 0, "R8"); sample(14'd16383, 0, "R8");
        idle(4);
        // R2: rounding at and near half steps
        load_set(40, 0, 0, 0);   sample(14'd100, 0, "R2");
        load_set(24, 0, 0, 0);   sample(14'd100, 0, "R2");
        load_set(-24, 0, 0, 0);  sample(14'd100, 0, "R2");
        load_set(-8, 0, 0, 0);   sample(14'd100, 0, "R2");
        load_set(-9, 0, 0, 0);   sample(14'd100, 0, "R2");
        // R9: each slot weights its own power of xs
        load_set(0, 256, 0, 0);  sample(14'd16383, 0, "R9"); sample(14'd0, 0, "R9");
        load_set(0, 0, 256, 0);  sample(14'd16383, 0, "R9"); sample(14'd0, 0, "R9");
        load_set(0, 0, 0, 256);  sample(14'd16383, 0, "R9"); sample(14'd0, 0, "R9");
        // R3: clipping on both rails
        load_set(32767, 0, 0, 0); sample(14'd5, 0, "R3");
        load_set(-32768, 0, 0, 0); sample(14'd5, 0, "R3");
        load_set(0, 0, 0, 32767); sample(14'd16383, 0, "R3"); sample(14'd0, 0, "R3");
        // R5: bypass wins over a saturating coefficient set
        load_set(32767, 0, 0, 0); sample(14'd7, 1, "R5"); sample(14'd7, 0, "R3");
        // R6: shadow write alone changes nothing
        step(0, '0, 0, 1, 2'd0, 16'd0, 0, "");
        sample(14'd42, 0, "R6"); sample(14'd9000, 0, "R6");
        // R7: sample on the load edge keeps the old set, next one uses the new
        step(1, 14'd42, 0, 0, '0, '0, 1, "R7");
        sample(14'd42, 0, "R7");
        // R10: back-to-back random traffic with coefficient churn, R1 model
        for (int i = 0; i < 4000; i++) begin
            logic v, byp, we, ld;
            logic [13:0] code;
            logic [15:0] data;
            v   = ($urandom % 4) != 0;
            byp = ($urandom % 8) == 0;
            case ($urandom % 8)
                0: code = 14'd0;
                1: code = 14'd16383;
                default: code = 14'($urandom);
            endcase
            we  = ($urandom % 12) == 0;
            data = (($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom_range(0, 1023) - 512);
            ld  = ($urandom % 24) == 0;
            step(v, code, byp, we, 2'($urandom), data, ld, (i < 200) ? "R10" : "");
        end
        idle(6);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule